// File: doc/BRIEF.md
# Bit-Masked GPIO Port

This block is an eight-line general-purpose I/O port that sits behind a simple byte-wide register bus. Each line is either an output, driven from an output data register, or an input, whose pad level passes through a two-flop synchroniser. A direction register selects the mode of each line. The port drives an output-enable and an output value to every pad.

Accesses to the data window use address bits [9:2] as a per-line mask. Software can therefore set, clear or sample any subset of lines in one transfer, with no read-modify-write sequence and no lock. A write to address `1 << (n+2)` changes line n and nothing else. A read from that address returns either zero or that line's bit in its own position. A small bank of identification bytes lets software confirm which peripheral sits at the base address.

The bus is a single-cycle strobe interface. A transfer is `busSel` high for one clock, with `busWrite` giving its direction. Write data is taken at that edge. Read data appears on `busRdata` after the same edge and holds until the next read.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset `padOe`, `padOut` and `busRdata` are all zero, so every line is an input.
- R2: Direction lives at offset 0x400. Bit n = 1 makes line n an output and bit n = 0 makes it an input. `padOe` equals this register from the clock after the write, and a read of 0x400 returns it.
- R3: A write to offset A in the data window (0x000 to 0x3FC, bits [11:10] = 0) updates only the output bits whose mask bit A[n+2] is 1. Every other output bit keeps its value.
- R4: A data write has no effect on a line that is an input at the time of the write. If that line later becomes an output, it drives its old output value until it is written again.
- R5: A data read returns 0 in every bit whose mask bit A[n+2] is 0.
- R6: In a data read, an unmasked output line returns its driven output value. An unmasked input line returns the pad level through two flops. A pad change made just before the clock edge that starts a read cycle is missed by a read sampled on the second edge after it, and is seen by a read sampled on the third.
- R7: The identification bytes at 0xFE0, 0xFE4, 0xFE8 and 0xFEC read 0x61, 0x10, 0x04 and 0x00, so the low 20 bits of the assembled ID are 0x41061.
- R8: Any other offset, and any offset with A[1:0] not equal to 0, is unmapped. It reads as 0, and a write to it changes neither `padOe` nor `padOut`.
- R9: `busRdata` is updated only on the clock edge that samples a read strobe, and it holds its value through idle and write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Transfer strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset of the access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| padIn | input | 8 | Pad input levels, asynchronous |
| padOe | output | 8 | Pad output enables, 1 = drive |
| padOut | output | 8 | Pad output values |

## Verification
A corrupted direction bit appears on `padOe` at once. It also shows up one write later as a pin that ignores, or wrongly accepts, a masked data write. A mask decode error shows up on the first write to a single-pin address, as a neighbouring `padOut` bit that moves. On reads, the same error shows as a non-zero bit outside the mask, visible on the cycle after the strobe. A synchroniser stage that is missing or extra moves the first read that sees a new pad level by exactly one cycle. The directed latency test exposes that within three clocks.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Decoded per-access strobes handed from the address decoder to the datapath
  typedef struct packed {
    logic       dataWr;   // masked write to the data window
    logic       dataRd;   // masked read of the data window
    logic       dirWr;    // write of the direction register
    logic       dirRd;    // read of the direction register
    logic       idRd;     // read of an identification byte
    logic [1:0] idIdx;    // which identification byte
    logic       rdAny;    // any read, mapped or not: reload read data
  } portStrobes_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int          LINES    = 8,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] DIR_OFFS = 12'h400,
  parameter logic [11:0] ID_OFFS  = 12'hFE0
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output portStrobes_t      strb,
  output logic [LINES-1:0]  accessMask
);

  localparam int WIN_TOP = LINES + 2;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFS);
  localparam logic [ADDR_W-1:0] ID_ADDR  = ADDR_W'(ID_OFFS);

  logic aligned;
  logic inData;
  logic inDir;
  logic inId;
  logic rdReq;
  logic wrReq;

  always_comb begin
    aligned = (busAddr[1:0] == 2'b00);
    inData  = aligned && (busAddr[ADDR_W-1:WIN_TOP] == '0);
    inDir   = aligned && (busAddr[ADDR_W-1:2] == DIR_ADDR[ADDR_W-1:2]);
    inId    = aligned && (busAddr[ADDR_W-1:4] == ID_ADDR[ADDR_W-1:4]);
    rdReq   = busSel && !busWrite;
    wrReq   = busSel && busWrite;

    strb.dataWr = wrReq && inData;
    strb.dataRd = rdReq && inData;
    strb.dirWr  = wrReq && inDir;
    strb.dirRd  = rdReq && inDir;
    strb.idRd   = rdReq && inId;
    strb.idIdx  = busAddr[3:2];
    strb.rdAny  = rdReq;
  end

  assign accessMask = busAddr[WIN_TOP-1:2];

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int                 LINES    = 8,
  parameter logic [4*LINES-1:0] ID_VALUE = 32'h0004_1061
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobes_t     strb,
  input  logic [LINES-1:0] accessMask,
  input  logic [LINES-1:0] busWdata,
  input  logic [LINES-1:0] padIn,
  output logic [LINES-1:0] busRdata,
  output logic [LINES-1:0] padOe,
  output logic [LINES-1:0] padOut
);

  logic [LINES-1:0] dirReg;
  logic [LINES-1:0] outReg;
  logic [LINES-1:0] syncA;
  logic [LINES-1:0] syncB;
  logic [LINES-1:0] rdReg;
  logic [LINES-1:0] lineView;
  logic [LINES-1:0] idByte;
  logic [LINES-1:0] readVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg <= '0;
      syncA  <= '0;
      syncB  <= '0;
      rdReg  <= '0;
    end else begin
      if (strb.dirWr) dirReg <= busWdata;
      syncA <= padIn;
      syncB <= syncA;
      if (strb.rdAny) rdReg <= readVal;
    end
  end

  // One update flop per line: a line takes new data only when it is
  // selected by the address mask and currently set as an output.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN)
        outReg[i] <= 1'b0;
      else if (strb.dataWr && accessMask[i] && dirReg[i])
        outReg[i] <= busWdata[i];
    end
    assign lineView[i] = dirReg[i] ? outReg[i] : syncB[i];
  end

  always_comb begin
    idByte = ID_VALUE[strb.idIdx*LINES +: LINES];
    if (strb.dataRd)
      readVal = lineView & accessMask;
    else if (strb.dirRd)
      readVal = dirReg;
    else if (strb.idRd)
      readVal = idByte;
    else
      readVal = '0;
  end

  assign busRdata = rdReg;
  assign padOe    = dirReg;
  assign padOut   = outReg;

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_port_pkg::*;
#(
  parameter int                 LINES    = 8,
  parameter int                 ADDR_W   = 12,
  parameter logic [4*LINES-1:0] ID_VALUE = 32'h0004_1061
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LINES-1:0]  busWdata,
  output logic [LINES-1:0]  busRdata,
  input  logic [LINES-1:0]  padIn,
  output logic [LINES-1:0]  padOe,
  output logic [LINES-1:0]  padOut
);

  portStrobes_t     strb;
  logic [LINES-1:0] accessMask;

  gpio_port_ctrl #(
    .LINES  (LINES),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .busSel     (busSel),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .strb       (strb),
    .accessMask (accessMask)
  );

  gpio_port_datapath #(
    .LINES    (LINES),
    .ID_VALUE (ID_VALUE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .accessMask (accessMask),
    .busWdata   (busWdata),
    .padIn      (padIn),
    .busRdata   (busRdata),
    .padOe      (padOe),
    .padOut     (padOut)
  );

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int LINES  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [LINES-1:0]  busRdata,
  input logic [LINES-1:0]  padOe,
  input logic [LINES-1:0]  padOut
);

  logic alignedC;
  logic winHit;
  logic dirHit;
  logic idHit;
  logic rdHit;
  logic dataWrHit;
  logic dataRdHit;
  logic dirWrHit;
  logic unmappedRd;
  logic [LINES-1:0] maskBits;

  assign alignedC   = (busAddr[1:0] == 2'b00);
  assign winHit     = alignedC && (busAddr < ADDR_W'(12'h400));
  assign dirHit     = (busAddr == ADDR_W'(12'h400));
  assign idHit      = alignedC && (busAddr >= ADDR_W'(12'hFE0)) && (busAddr <= ADDR_W'(12'hFEC));
  assign rdHit      = busSel && !busWrite;
  assign dataWrHit  = busSel && busWrite && winHit;
  assign dataRdHit  = rdHit && winHit;
  assign dirWrHit   = busSel && busWrite && dirHit;
  assign unmappedRd = rdHit && !winHit && !dirHit && !idHit;
  assign maskBits   = busAddr[LINES+1:2];

  AST_OE_ONLY_BY_DIR_WRITE: assert property (@(posedge clk) disable iff (!rstN) !$stable(padOe) |-> $past(dirWrHit)); // R2
  AST_OUT_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rstN) ((padOut ^ $past(padOut)) & ~($past(maskBits) & {LINES{$past(dataWrHit)}})) == '0); // R3
  AST_INPUT_LINE_FROZEN: assert property (@(posedge clk) disable iff (!rstN) ((padOut ^ $past(padOut)) & ~$past(padOe)) == '0); // R4
  AST_READ_OUTSIDE_MASK_ZERO: assert property (@(posedge clk) disable iff (!rstN) $past(dataRdHit) |-> ((busRdata & ~$past(maskBits)) == '0)); // R5
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN) $past(unmappedRd) |-> (busRdata == '0)); // R8
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rstN) !$past(rdHit) |-> $stable(busRdata)); // R9

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
  .LINES  (LINES),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .padOe    (padOe),
  .padOut   (padOut)
);

// File: tb/sim_gpio_mask_port.sv
module sim_gpio_mask_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOe;
  logic [7:0]  padOut;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  gpio_mask_port u0 (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOe    (padOe),
    .padOut   (padOut)
  );

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic testReset();
    logic [7:0] v;
    chk("R1 padOe after reset", padOe, 8'h00);
    chk("R1 padOut after reset", padOut, 8'h00);
    chk("R1 busRdata after reset", busRdata, 8'h00);
    busRd(12'h400, v);
    chk("R1 direction after reset", v, 8'h00);
  endtask

  task automatic testDirection();
    logic [7:0] v;
    busWr(12'h400, 8'hA5);
    chk("R2 padOe follows direction", padOe, 8'hA5);
    busRd(12'h400, v);
    chk("R2 direction readback", v, 8'hA5);
  endtask

  task automatic testMaskedWrite();
    busWr(12'h400, 8'hFF);
    busWr(12'h3FC, 8'h00);
    chk("R3 full-mask clear", padOut, 8'h00);
    busWr(12'h020, 8'hFF);
    chk("R3 single line 3 write", padOut, 8'h08);
    busWr(12'h3FC, 8'h5A);
    chk("R3 full-mask write", padOut, 8'h5A);
    busWr(12'h00C, 8'hFF);
    chk("R3 lines 0 and 1 only", padOut, 8'h5B);
    busWr(12'h000, 8'h00);
    chk("R3 empty mask writes nothing", padOut, 8'h5B);
  endtask

  task automatic testInputWrite();
    busWr(12'h400, 8'h0F);
    busWr(12'h3FC, 8'h00);
    chk("R4 input lines keep value", padOut, 8'h50);
    busWr(12'h3FC, 8'hFF);
    chk("R4 write to inputs dropped", padOut, 8'h5F);
    busWr(12'h400, 8'hFF);
    chk("R4 old value after switch to output", padOut, 8'h5F);
    busWr(12'h3FC, 8'hFF);
    chk("R4 rewrite after switch", padOut, 8'hFF);
  endtask

  task automatic testRead();
    logic [7:0] v;
    busWr(12'h400, 8'h0F);
    padIn = 8'h3C;
    repeat (4) @(negedge clk);
    busRd(12'h3FC, v);
    chk("R6 mixed out/in read", v, 8'h3F);
    busRd(12'h010, v);
    chk("R5 single output line 2", v, 8'h04);
    busRd(12'h080, v);
    chk("R5 single input line 5", v, 8'h20);
    busRd(12'h200, v);
    chk("R5 single input line 7 low", v, 8'h00);
    busRd(12'h000, v);
    chk("R5 empty mask reads zero", v, 8'h00);
    padIn = 8'hC0;
    busRd(12'h3FC, v);
    chk("R6 synchroniser hides new level", v, 8'h3F);
    busRd(12'h3FC, v);
    chk("R6 synchroniser passes new level", v, 8'hCF);
  endtask

  task automatic testId();
    logic [7:0] v;
    busRd(12'hFE0, v); chk("R7 id byte 0", v, 8'h61);
    busRd(12'hFE4, v); chk("R7 id byte 1", v, 8'h10);
    busRd(12'hFE8, v); chk("R7 id byte 2", v, 8'h04);
    busRd(12'hFEC, v); chk("R7 id byte 3", v, 8'h00);
  endtask

  task automatic testUnmapped();
    logic [7:0] v;
    busWr(12'h404, 8'hFF);
    busWr(12'h800, 8'h00);
    busWr(12'h401, 8'hFF);
    busWr(12'h3FD, 8'h00);
    chk("R8 padOe untouched", padOe, 8'h0F);
    chk("R8 padOut untouched", padOut, 8'hFF);
    busRd(12'h404, v); chk("R8 read 0x404", v, 8'h00);
    busRd(12'hFF0, v); chk("R8 read 0xFF0", v, 8'h00);
    busRd(12'h3FD, v); chk("R8 misaligned data read", v, 8'h00);
  endtask

  task automatic testHold();
    logic [7:0] v;
    busRd(12'hFE0, v);
    repeat (3) @(negedge clk);
    chk("R9 hold through idle", busRdata, 8'h61);
    busWr(12'h3FC, 8'h00);
    chk("R9 hold through write", busRdata, 8'h61);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirection();
    testMaskedWrite();
    testInputWrite();
    testRead();
    testId();
    testUnmapped();
    testHold();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule